// File: doc/BRIEF.md
# Configuration-Bit Upset Sweep Controller

This block measures which configuration-memory bits of a programmable device matter to a design under test. It walks every frame of a chosen range of major columns. For each bit in a frame it reads the whole frame through a generic frame read/write port and writes it back with only that bit inverted. It then launches the design under test and waits for it to finish. The design is judged against a stored golden result. A timeout or a different result marks the bit as sensitive. The original frame is then written back before the next bit is tried. Only the frame that was touched is ever repaired; nothing else in the device is reloaded.

Frames are named by a hierarchical address. The minor-frame count of a column follows from a per-column kind code. A per-column skip mask keeps the controller's own frames out of the sweep. Sensitive bits are queued in a small FIFO as {frame address, word, bit} records, which the surrounding system drains at its own pace. The state machine has ten states. IDLE and DONE wait for `start`. SEEK checks the current column: it goes to DONE past the end, stays in SEEK while skipping a blocked column, and otherwise moves to READ. The remaining states run in a fixed chain: READ, then INJECT, then LAUNCH, then WAIT until the run finishes, then RESTORE. RESTORE leads to LOG for a hit or to STEP otherwise. LOG moves to STEP once the FIFO has room, and STEP returns to SEEK.

Top module: `fi_sweep_ctrl`

## Requirements
- R1: After reset, and whenever no sweep is running, `busy`, `sweep_done`, `hit_valid`, `fr_rd_en`, `fr_wr_en` and `dut_start` are all 0.
- R2: `fr_addr` and `cur_frame` are packed MSB first as {block[2:0], half[0], row[ROW_W-1:0], major[COL_W-1:0], minor[6:0]}. The half and row fields are copied from `half_top` and `row_sel`. The block field is 1 for kind 4, 2 for kind 5 and 0 for kinds 0 to 3.
- R3: Column c takes its kind from `col_kinds[3c+2:3c]`. The minor-frame counts per kind are: 0 gives 22, 1 gives 21, 2 gives 30, 3 gives 3, 4 gives 20 and 5 gives 64. Minor frames are numbered from 0 upward. Kinds 6 and 7 have no frames, so those columns are never accessed.
- R4: Major columns are visited in ascending order from `col_first` to `col_last` inclusive. A column whose `col_skip` bit is 1 receives no frame access. When `col_first` exceeds `col_last`, the sweep ends with no access.
- R5: Within a frame, bit positions p are tried from 0 to FRAME_BITS-1 when `half_top` is 0, and from FRAME_BITS-1 down to 0 when `half_top` is 1. Position p is bit p mod WORD_W of word p / WORD_W.
- R6: Each try does the following in order. It reads all words of the frame, with `fr_rdata` taken in the same cycle as the address. It writes all words back with only the target bit inverted. It raises `dut_start` for one cycle. After the run it writes all words back unmodified. So each try makes 2·FRAME_WORDS writes, all to the frame under test, and no port access happens while `dut_start` is high.
- R7: A run that ends with `dut_done` while `dut_result` differs from `golden` marks the bit as sensitive. A run that ends with equal values does not.
- R8: If `dut_done` is not seen within `run_len` cycles, counted from the cycle after `dut_start`, the run is stopped and the bit is marked sensitive.
- R9: Each sensitive bit produces one record {frame address, word index, bit index} in sweep order. `hit_valid` and `hit_data` show the oldest record and hold it until `hit_pop` is high at a clock edge.
- R10: While the record FIFO is full, the sweep waits and loses no record. `busy` stays 1 and `cur_frame` holds the frame being reported.
- R11: At the end of a sweep `busy` falls and `sweep_done` rises. `sweep_done` holds until the next accepted `start`. The frame memory then matches its content from before the sweep.
- R12: A `start` pulse while `busy` is 1 is ignored. It changes neither the sequence of runs nor the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle or finished |
| col_first | input | COL_W | First major column of the range |
| col_last | input | COL_W | Last major column of the range |
| col_kinds | input | 3·2^COL_W | Kind code of every column, 3 bits each |
| col_skip | input | 2^COL_W | 1 = column excluded from the sweep |
| half_top | input | 1 | Half flag placed in the address; selects descending bit order |
| row_sel | input | ROW_W | Clock-row index placed in the address |
| run_len | input | TMR_W | Run limit in cycles |
| golden | input | RES_W | Expected result of an undisturbed run |
| fr_rd_en | output | 1 | Frame word read strobe |
| fr_wr_en | output | 1 | Frame word write strobe |
| fr_addr | output | FA_W | Frame address |
| fr_word | output | WI_W | Word index within the frame |
| fr_wdata | output | WORD_W | Write data |
| fr_rdata | input | WORD_W | Read data, same cycle as the address |
| dut_start | output | 1 | One-cycle launch of the design under test |
| dut_done | input | 1 | Design under test finished |
| dut_result | input | RES_W | Observed result of the run |
| busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | Sweep finished |
| cur_frame | output | FA_W | Frame currently under test |
| hit_valid | output | 1 | A sensitive-bit record is available |
| hit_data | output | HIT_W | Oldest record {frame address, word, bit} |
| hit_pop | input | 1 | Remove the oldest record |

## Verification
A wrong column, minor or bit position in the walker shows at once on `fr_addr`, and on the word and bit fields of the next record. It also shows in the count of `dut_start` pulses and in per-column access counts at the end of the sweep. A frame buffer that captures or inverts the wrong word makes the design under test report spurious or missing hits within one run. It also leaves the frame memory different from its original content once the sweep ends. A timer or compare fault shows as a missing, extra or reordered record at the FIFO head, at the latest one try after the run concerned. A FIFO or stall fault shows as a lost record or as a sweep that ends while records are still held back.

// File: rtl/fi_pkg.sv
package fi_pkg;

    localparam int MINOR_W = 7;
    localparam int BLK_W   = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEEK,
        ST_READ,
        ST_INJECT,
        ST_LAUNCH,
        ST_WAIT,
        ST_RESTORE,
        ST_LOG,
        ST_STEP,
        ST_DONE
    } sweep_state_t;

    // Minor frames per column kind; zero means the column holds no frames.
    function automatic logic [MINOR_W-1:0] minor_count(input logic [2:0] kind);
        logic [MINOR_W-1:0] n;
        unique case (kind)
            3'd0:    n = 7'd22;
            3'd1:    n = 7'd21;
            3'd2:    n = 7'd30;
            3'd3:    n = 7'd3;
            3'd4:    n = 7'd20;
            3'd5:    n = 7'd64;
            default: n = 7'd0;
        endcase
        return n;
    endfunction

    // Block field of the frame address for a column kind.
    function automatic logic [BLK_W-1:0] block_code(input logic [2:0] kind);
        logic [BLK_W-1:0] b;
        unique case (kind)
            3'd4:    b = 3'd1;
            3'd5:    b = 3'd2;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fi_addr_walker.sv
module fi_addr_walker #(
    parameter int COL_W      = 6,
    parameter int WORD_W     = 32,
    parameter int FRAME_BITS = 1312,
    parameter int K_W        = 11,
    parameter int WI_W       = 6,
    parameter int BI_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             skip,
    input  logic             step,
    input  logic [COL_W-1:0] col_first,
    input  logic [6:0]       minor_cnt,
    input  logic             half_top,
    output logic [COL_W:0]   col,
    output logic [6:0]       minor,
    output logic [WI_W-1:0]  tword,
    output logic [BI_W-1:0]  tbit
);

    localparam logic [K_W-1:0] K_LAST = K_W'(FRAME_BITS - 1);
    localparam logic [K_W-1:0] K_WORD = K_W'(WORD_W);

    logic [K_W-1:0] k;
    logic [K_W-1:0] phys;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col   <= '0;
            minor <= '0;
            k     <= '0;
        end else if (init) begin
            col   <= {1'b0, col_first};
            minor <= '0;
            k     <= '0;
        end else if (skip) begin
            col   <= col + 1'b1;
            minor <= '0;
            k     <= '0;
        end else if (step) begin
            if (k == K_LAST) begin
                k <= '0;
                if (minor == minor_cnt - 7'd1) begin
                    minor <= '0;
                    col   <= col + 1'b1;
                end else begin
                    minor <= minor + 7'd1;
                end
            end else begin
                k <= k + 1'b1;
            end
        end
    end

    // Upper-half frames run from the last bit downward.
    always_comb begin
        phys  = half_top ? (K_LAST - k) : k;
        tword = WI_W'(phys / K_WORD);
        tbit  = BI_W'(phys % K_WORD);
    end

endmodule

// File: rtl/fi_frame_buf.sv
module fi_frame_buf #(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 41,
    parameter int WI_W        = 6,
    parameter int BI_W        = 5
) (
    input  logic              clk,
    input  logic              cap_en,
    input  logic [WI_W-1:0]   idx,
    input  logic [WORD_W-1:0] din,
    input  logic              inject,
    input  logic [WI_W-1:0]   tword,
    input  logic [BI_W-1:0]   tbit,
    output logic [WORD_W-1:0] dout
);

    logic [WORD_W-1:0] store [FRAME_WORDS];
    logic [WORD_W-1:0] flip_mask;

    always_ff @(posedge clk) begin
        if (cap_en) begin
            store[idx] <= din;
        end
    end

    always_comb begin
        flip_mask = '0;
        if (inject && (idx == tword)) begin
            flip_mask = WORD_W'(1) << tbit;
        end
        dout = store[idx] ^ flip_mask;
    end

endmodule

// File: rtl/fi_run_timer.sv
module fi_run_timer #(
    parameter int RES_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             dut_done,
    input  logic [RES_W-1:0] dut_result,
    input  logic [RES_W-1:0] golden,
    input  logic [TMR_W-1:0] run_len,
    output logic             fin,
    output logic             hit
);

    logic             active;
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            cnt    <= TMR_W'(1);
        end else if (fin) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        fin = active && (dut_done || (cnt >= run_len));
        hit = fin && (!dut_done || (dut_result != golden));
    end

endmodule

// File: rtl/fi_hit_fifo.sv
module fi_hit_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] dout
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] store [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                store[wp[AW-1:0]] <= din;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) begin
                rp <= rp + 1'b1;
            end
        end
    end

    always_comb begin
        empty = (wp == rp);
        full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        dout  = store[rp[AW-1:0]];
    end

endmodule

// File: rtl/fi_sweep_ctrl.sv
module fi_sweep_ctrl #(
    parameter int COL_W       = 6,
    parameter int ROW_W       = 4,
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 41,
    parameter int RES_W       = 16,
    parameter int TMR_W       = 16,
    parameter int FIFO_DEPTH  = 16,
    localparam int NUM_COLS   = 1 << COL_W,
    localparam int FRAME_BITS = FRAME_WORDS * WORD_W,
    localparam int K_W        = $clog2(FRAME_BITS),
    localparam int WI_W       = $clog2(FRAME_WORDS),
    localparam int BI_W       = $clog2(WORD_W),
    localparam int FA_W       = fi_pkg::BLK_W + 1 + ROW_W + COL_W + fi_pkg::MINOR_W,
    localparam int HIT_W      = FA_W + WI_W + BI_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [COL_W-1:0]      col_first,
    input  logic [COL_W-1:0]      col_last,
    input  logic [3*NUM_COLS-1:0] col_kinds,
    input  logic [NUM_COLS-1:0]   col_skip,
    input  logic                  half_top,
    input  logic [ROW_W-1:0]      row_sel,
    input  logic [TMR_W-1:0]      run_len,
    input  logic [RES_W-1:0]      golden,
    output logic                  fr_rd_en,
    output logic                  fr_wr_en,
    output logic [FA_W-1:0]       fr_addr,
    output logic [WI_W-1:0]       fr_word,
    output logic [WORD_W-1:0]     fr_wdata,
    input  logic [WORD_W-1:0]     fr_rdata,
    output logic                  dut_start,
    input  logic                  dut_done,
    input  logic [RES_W-1:0]      dut_result,
    output logic                  busy,
    output logic                  sweep_done,
    output logic [FA_W-1:0]       cur_frame,
    output logic                  hit_valid,
    output logic [HIT_W-1:0]      hit_data,
    input  logic                  hit_pop
);

    import fi_pkg::*;

    sweep_state_t state_q, state_d;

    logic [COL_W:0]    w_col;
    logic [6:0]        w_minor;
    logic [WI_W-1:0]   w_tword;
    logic [BI_W-1:0]   w_tbit;
    logic [2:0]        cur_kind;
    logic [6:0]        cur_cnt;
    logic [BLK_W-1:0]  cur_blk;
    logic              past_end;
    logic              col_blocked;
    logic [WI_W-1:0]   wcnt;
    logic              word_last;
    logic              hit_q;
    logic              walk_init, walk_skip, walk_step;
    logic              buf_cap, buf_inject, tmr_launch;
    logic              tmr_fin, tmr_hit;
    logic              fifo_push, fifo_full, fifo_empty;
    logic [FA_W-1:0]   frame_id;

    fi_addr_walker #(
        .COL_W(COL_W), .WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS),
        .K_W(K_W), .WI_W(WI_W), .BI_W(BI_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .init(walk_init), .skip(walk_skip),
        .step(walk_step), .col_first(col_first), .minor_cnt(cur_cnt),
        .half_top(half_top), .col(w_col), .minor(w_minor),
        .tword(w_tword), .tbit(w_tbit)
    );

    fi_frame_buf #(
        .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .WI_W(WI_W), .BI_W(BI_W)
    ) u_buf (
        .clk(clk), .cap_en(buf_cap), .idx(wcnt), .din(fr_rdata),
        .inject(buf_inject), .tword(w_tword), .tbit(w_tbit), .dout(fr_wdata)
    );

    fi_run_timer #(.RES_W(RES_W), .TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .launch(tmr_launch), .dut_done(dut_done),
        .dut_result(dut_result), .golden(golden), .run_len(run_len),
        .fin(tmr_fin), .hit(tmr_hit)
    );

    fi_hit_fifo #(.W(HIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push),
        .din({frame_id, w_tword, w_tbit}), .pop(hit_pop),
        .full(fifo_full), .empty(fifo_empty), .dout(hit_data)
    );

    // Column lookup and frame naming.
    always_comb begin
        cur_kind    = col_kinds[3*int'(w_col[COL_W-1:0]) +: 3];
        cur_cnt     = minor_count(cur_kind);
        cur_blk     = block_code(cur_kind);
        past_end    = w_col > {1'b0, col_last};
        col_blocked = col_skip[w_col[COL_W-1:0]] || (cur_cnt == 7'd0);
        word_last   = (wcnt == WI_W'(FRAME_WORDS - 1));
        frame_id    = {cur_blk, half_top, row_sel, w_col[COL_W-1:0], w_minor};
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word counter and per-try verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            hit_q <= 1'b0;
        end else begin
            if (state_q inside {ST_READ, ST_INJECT, ST_RESTORE}) begin
                wcnt <= word_last ? '0 : wcnt + 1'b1;
            end else begin
                wcnt <= '0;
            end
            if ((state_q == ST_WAIT) && tmr_fin) begin
                hit_q <= tmr_hit;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_SEEK;
            ST_SEEK: begin
                if (past_end)         state_d = ST_DONE;
                else if (col_blocked) state_d = ST_SEEK;
                else                  state_d = ST_READ;
            end
            ST_READ:    if (word_last) state_d = ST_INJECT;
            ST_INJECT:  if (word_last) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_WAIT;
            ST_WAIT:    if (tmr_fin) state_d = ST_RESTORE;
            ST_RESTORE: if (word_last) state_d = hit_q ? ST_LOG : ST_STEP;
            ST_LOG:     if (!fifo_full) state_d = ST_STEP;
            ST_STEP:    state_d = ST_SEEK;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes.
    always_comb begin
        walk_init  = (state_q inside {ST_IDLE, ST_DONE}) && start;
        walk_skip  = (state_q == ST_SEEK) && !past_end && col_blocked;
        walk_step  = (state_q == ST_STEP);
        buf_cap    = (state_q == ST_READ);
        buf_inject = (state_q == ST_INJECT);
        tmr_launch = (state_q == ST_LAUNCH);
        fifo_push  = (state_q == ST_LOG) && !fifo_full;
        fr_rd_en   = (state_q == ST_READ);
        fr_wr_en   = (state_q == ST_INJECT) || (state_q == ST_RESTORE);
        fr_addr    = frame_id;
        fr_word    = wcnt;
        dut_start  = tmr_launch;
        busy       = !(state_q inside {ST_IDLE, ST_DONE});
        sweep_done = (state_q == ST_DONE);
        cur_frame  = frame_id;
        hit_valid  = !fifo_empty;
    end

endmodule

// File: rtl/fi_sweep_ctrl_chk.sv
module fi_sweep_ctrl_chk #(
    parameter int HIT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sweep_done,
    input logic             fr_rd_en,
    input logic             fr_wr_en,
    input logic             dut_start,
    input logic             hit_valid,
    input logic             hit_pop,
    input logic [HIT_W-1:0] hit_data
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fr_rd_en && !fr_wr_en && !dut_start));

    // R6
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fr_rd_en && fr_wr_en));

    // R6
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dut_start |=> !dut_start);

    // R6
    launch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dut_start |-> (!fr_rd_en && !fr_wr_en));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_pop) |=> (hit_valid && $stable(hit_data)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> !busy);

    // R11
    finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sweep_done);

endmodule

bind fi_sweep_ctrl fi_sweep_ctrl_chk #(.HIT_W(HIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sweep_done(sweep_done),
    .fr_rd_en(fr_rd_en), .fr_wr_en(fr_wr_en), .dut_start(dut_start),
    .hit_valid(hit_valid), .hit_pop(hit_pop), .hit_data(hit_data)
);

// File: tb/fi_sweep_ctrl_test.sv
module fi_sweep_ctrl_test;

    localparam int COL_W = 2, ROW_W = 3, WORD_W = 4, FRAME_WORDS = 2;
    localparam int RES_W = 8, TMR_W = 8, DEPTH = 4;
    localparam int FA_W = 3 + 1 + ROW_W + COL_W + 7;
    localparam int HIT_W = FA_W + 1 + 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [COL_W-1:0] col_first = '0, col_last = '0;
    logic [11:0] col_kinds = '0;
    logic [3:0] col_skip = '0;
    logic half_top = 1'b0;
    logic [ROW_W-1:0] row_sel = '0;
    logic [TMR_W-1:0] run_len = 8'd8;
    logic [RES_W-1:0] golden;
    logic fr_rd_en, fr_wr_en, dut_start, dut_done, busy, sweep_done, hit_valid;
    logic hit_pop = 1'b0;
    logic [FA_W-1:0] fr_addr, cur_frame;
    logic [0:0] fr_word;
    logic [WORD_W-1:0] fr_wdata, fr_rdata;
    logic [RES_W-1:0] dut_result;
    logic [HIT_W-1:0] hit_data;

    int checks = 0, errors = 0;
    logic [3:0] mem  [4][64][2];
    logic [3:0] orig [4][64][2];
    int rd_cnt [4];
    int wr_cnt [4];
    int starts = 0, bad_fields = 0;
    logic [2:0] exp_blk [4];
    logic [2:0] dcnt;
    logic collect_en = 1'b0;
    logic [HIT_W-1:0] got [64];
    int ngot = 0;

    fi_sweep_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W), .WORD_W(WORD_W),
        .FRAME_WORDS(FRAME_WORDS), .RES_W(RES_W), .TMR_W(TMR_W),
        .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .col_first(col_first),
        .col_last(col_last), .col_kinds(col_kinds), .col_skip(col_skip),
        .half_top(half_top), .row_sel(row_sel), .run_len(run_len),
        .golden(golden), .fr_rd_en(fr_rd_en), .fr_wr_en(fr_wr_en),
        .fr_addr(fr_addr), .fr_word(fr_word), .fr_wdata(fr_wdata),
        .fr_rdata(fr_rdata), .dut_start(dut_start), .dut_done(dut_done),
        .dut_result(dut_result), .busy(busy), .sweep_done(sweep_done),
        .cur_frame(cur_frame), .hit_valid(hit_valid), .hit_data(hit_data),
        .hit_pop(hit_pop)
    );

    always #5ns clk = ~clk;

    // Frame memory model: combinational read, write on the clock edge.
    assign fr_rdata = mem[fr_addr[8:7]][fr_addr[5:0]][fr_word];

    always @(posedge clk) begin
        if (fr_rd_en || fr_wr_en) begin
            if (fr_addr[15:13] != exp_blk[fr_addr[8:7]] || fr_addr[12] != half_top ||
                fr_addr[11:9] != row_sel || fr_addr[6])
                bad_fields++;
            if (fr_rd_en) rd_cnt[fr_addr[8:7]]++;
            if (fr_wr_en) begin
                wr_cnt[fr_addr[8:7]]++;
                mem[fr_addr[8:7]][fr_addr[5:0]][fr_word] <= fr_wdata;
            end
        end
        if (dut_start) starts++;
    end

    // Behavioural design under test: finishes 5 cycles after launch,
    // reports column 0 minor 2, and hangs when one bit of column 2 minor 5 is upset.
    always @(posedge clk) begin
        if (!rst_n) dcnt <= '0;
        else if (dut_start) dcnt <= 3'd1;
        else if (dcnt != 0 && dcnt < 3'd6) dcnt <= dcnt + 3'd1;
    end
    assign dut_done   = (dcnt == 3'd5) && (mem[2][5][1][2] == orig[2][5][1][2]);
    assign dut_result = {mem[0][2][1], mem[0][2][0]};
    assign golden     = {orig[0][2][1], orig[0][2][0]};

    always @(negedge clk) begin
        if (collect_en && hit_valid) begin
            got[ngot] = hit_data;
            ngot++;
            hit_pop = 1'b1;
        end else begin
            hit_pop = 1'b0;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] kind_blk(input logic [2:0] kind);
        if (kind == 3'd4) return 3'd1;
        if (kind == 3'd5) return 3'd2;
        return 3'd0;
    endfunction

    function automatic logic [HIT_W-1:0] mk_hit(input int blk, input int half,
        input int row, input int col, input int minor, input int k);
        int p;
        p = half ? 7 - k : k;
        return {3'(blk), 1'(half), 3'(row), 2'(col), 7'(minor), 1'(p / 4), 2'(p % 4)};
    endfunction

    task automatic setup(input logic [11:0] kinds);
        col_kinds = kinds;
        for (int c = 0; c < 4; c++) begin
            exp_blk[c] = kind_blk(kinds[3*c +: 3]);
            rd_cnt[c] = 0;
            wr_cnt[c] = 0;
        end
        ngot = 0;
        starts = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        while (!sweep_done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic mem_intact(input string req);
        int bad = 0;
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 64; m++)
                for (int w = 0; w < 2; w++)
                    if (mem[c][m][w] != orig[c][m][w]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 sweep_done", sweep_done, 0);
        chk("R1 hit_valid", hit_valid, 0);
        chk("R1 port", {fr_rd_en, fr_wr_en, dut_start}, 0);
    endtask

    // Bottom half, mixed kinds, one column skipped, one of a frameless kind.
    task automatic t_sweep_mixed();
        setup({3'd6, 3'd4, 3'd3, 3'd3});
        col_first = 2'd0; col_last = 2'd3; col_skip = 4'b0010;
        half_top = 1'b0; row_sel = 3'd5; run_len = 8'd8;
        collect_en = 1'b1;
        pulse_start();
        wait_done();
        chk("R3 R4 runs", starts, 24 + 160);
        chk("R6 writes col0", wr_cnt[0], 24 * 4);
        chk("R6 reads col2", rd_cnt[2], 160 * 2);
        chk("R4 skipped column", rd_cnt[1] + wr_cnt[1], 0);
        chk("R3 frameless kind", rd_cnt[3] + wr_cnt[3], 0);
        chk("R2 address fields", bad_fields, 0);
        chk("R9 count", ngot, 9);
        for (int k = 0; k < 8; k++)
            chk("R7 R5 record", got[k], mk_hit(0, 0, 5, 0, 2, k));
        chk("R8 timeout record", got[8], mk_hit(1, 0, 5, 2, 5, 6));
        mem_intact("R11 restore");
        chk("R11 flags", {busy, sweep_done}, 2'b01);
        repeat (10) @(negedge clk);
        chk("R11 done held", sweep_done, 1);
    endtask

    // Top half with the record queue left undrained.
    task automatic t_sweep_stall();
        setup({3'd6, 3'd4, 3'd3, 3'd3});
        col_first = 2'd0; col_last = 2'd0; col_skip = 4'b0000;
        half_top = 1'b1; row_sel = 3'd2; run_len = 8'd8;
        collect_en = 1'b0;
        pulse_start();
        repeat (1500) @(negedge clk);
        chk("R10 still busy", {busy, sweep_done}, 2'b10);
        chk("R10 R2 frame held", cur_frame, {3'd0, 1'b1, 3'd2, 2'd0, 7'd2});
        pulse_start();
        collect_en = 1'b1;
        wait_done();
        chk("R10 no loss", ngot, 8);
        for (int k = 0; k < 8; k++)
            chk("R5 R10 top-half record", got[k], mk_hit(0, 1, 2, 0, 2, k));
        chk("R12 runs", starts, 24);
        mem_intact("R11 restore");
    endtask

    // Run limit below the design latency: every bit times out.
    task automatic t_sweep_timeout();
        setup({3'd6, 3'd4, 3'd3, 3'd3});
        col_first = 2'd0; col_last = 2'd0;
        half_top = 1'b0; row_sel = 3'd1; run_len = 8'd2;
        collect_en = 1'b1;
        pulse_start();
        wait_done();
        chk("R8 all timed out", ngot, 24);
        chk("R8 first", got[0], mk_hit(0, 0, 1, 0, 0, 0));
        chk("R8 last", got[23], mk_hit(0, 0, 1, 0, 2, 7));
        mem_intact("R11 restore");
    endtask

    task automatic t_sweep_empty();
        setup({3'd6, 3'd4, 3'd3, 3'd3});
        col_first = 2'd3; col_last = 2'd1; run_len = 8'd8;
        pulse_start();
        wait_done();
        chk("R4 empty range runs", starts, 0);
        chk("R4 empty range access", rd_cnt[0] + rd_cnt[1] + rd_cnt[2] + rd_cnt[3], 0);
        chk("R11 empty done", {busy, sweep_done}, 2'b01);
    endtask

    initial begin
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 64; m++)
                for (int w = 0; w < 2; w++) begin
                    mem[c][m][w]  = 4'((c * 7 + m * 3 + w * 5 + 1) & 15);
                    orig[c][m][w] = 4'((c * 7 + m * 3 + w * 5 + 1) & 15);
                end
        setup({3'd6, 3'd4, 3'd3, 3'd3});
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep_mixed();
        t_sweep_stall();
        t_sweep_timeout();
        t_sweep_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule